// File: doc/BRIEF.md
# Segment Waveform Sequencer

The sequencer plays stored waveforms as an ordered list of segments for an arbitrary waveform generator. Each entry in the segment table gives a start word address, a length in words, a loop count and a marker word offset. The sample memory is 64 bits wide and holds four 16-bit samples per word. All lengths, positions and loop boundaries are therefore counted in words. Every waveform length and marker position is a multiple of four samples by construction.

Software fills the table through a write port, then selects the last active entry, the trigger mode and the trigger source, and pulses `start_i`. The block generates read addresses into the sample memory, which has a one-cycle read latency, and streams the returned words over a valid/ready interface. It also raises a marker flag on the word that holds the marker position. A rising edge on `trig_i`, or the immediate source, starts play. Depending on the mode, triggers also step or advance the sequence.

Top module: `seg_sequencer`

## Requirements
- R1: A write with `cfg_we_i` high stores `cfg_data_i` into one field of entry `cfg_idx_i`, the field chosen by `cfg_field_i`: 0 start word address, 1 length in words, 2 loop count, 3 marker word offset.
- R2: A segment outputs the words at start+0 through start+len-1, in order, once per loop. Segments follow in index order, and entry `seg_last_i` wraps to entry 0.
- R3: While `out_ready_i` stays high, the output words follow one another with no idle cycle, across loop and segment boundaries. While `out_valid_o` is high and `out_ready_i` is low, the word and the valid flag hold.
- R4: `marker_o` is high together with the output word at offset `marker` inside the segment, on every loop, and never while no word is valid.
- R5: Mode 0 (single) plays entries 0 to `seg_last_i` once after the trigger, then returns to idle with `busy_o` low.
- R6: Mode 1 (continuous) repeats the whole sequence until it is aborted.
- R7: Mode 2 (stepped) plays one segment, with all its loops, for each trigger. It then drops `out_valid_o` while `out_data_o` keeps the last word.
- R8: Mode 3 (burst) repeats the current segment regardless of its loop count. After a trigger it moves to the next segment at the end of the iteration in progress.
- R9: A trigger is a rising edge of `trig_i`, so a level held high counts once. With `trig_imm_i` high, play starts without any edge. Before a trigger, no word is output.
- R10: A segment whose loop count is zero, or whose length is under 4 words in single mode or under 8 words in the other modes, raises `err_o` for one cycle and is skipped.
- R11: `abort_i` makes `out_valid_o` and `busy_o` low on the next cycle.
- R12: After reset `out_valid_o`, `marker_o`, `err_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table field write strobe |
| cfg_idx_i | input | SEG_W | Table entry to write |
| cfg_field_i | input | 2 | Field select |
| cfg_data_i | input | CFG_W | Field value |
| seg_last_i | input | SEG_W | Index of the last active entry |
| mode_i | input | 2 | 0 single, 1 continuous, 2 stepped, 3 burst |
| trig_imm_i | input | 1 | Immediate trigger source |
| start_i | input | 1 | Arms the sequence at entry 0 |
| trig_i | input | 1 | Start trigger, rising edge |
| abort_i | input | 1 | Synchronous abort to idle |
| mem_rd_o | output | 1 | Sample memory read enable |
| mem_addr_o | output | ADDR_W | Sample memory word address |
| mem_data_i | input | WORD_W | Read word, one cycle after the address |
| out_data_o | output | WORD_W | Four output samples |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream accepts the word |
| marker_o | output | 1 | Marker flag for the current word |
| err_o | output | 1 | Illegal segment skipped |
| busy_o | output | 1 | Sequence armed or words in flight |

## Verification
The bench builds the block with an 8-bit word address and an 8-entry table. Three active entries are enough to exercise wrap-around, every mode, stepping and burst advance within a few hundred cycles. Short waveforms of 6 to 10 words put the 4-word and 8-word minimum-length limits next to ordinary lengths. Random backpressure on `out_ready_i` drives the stall and hold paths of the memory pipeline.

// File: rtl/seg_seq_pkg.sv
package seg_seq_pkg;
  localparam int SMP_PER_WORD = 4;
  localparam int LOOP_W       = 24;

  typedef enum logic [1:0] {
    M_SINGLE = 2'd0,
    M_CONT   = 2'd1,
    M_STEP   = 2'd2,
    M_BURST  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_PLAY = 2'd2
  } state_e;

  localparam logic [1:0] F_START = 2'd0;
  localparam logic [1:0] F_LEN   = 2'd1;
  localparam logic [1:0] F_LOOPS = 2'd2;
  localparam logic [1:0] F_MARK  = 2'd3;
endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_seq_pkg::*;
#(
  parameter int SEG_N  = 256,
  parameter int ADDR_W = 20,
  parameter int CFG_W  = 24,
  localparam int SEG_W = $clog2(SEG_N)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [SEG_W-1:0]  widx_i,
  input  logic [1:0]        field_i,
  input  logic [CFG_W-1:0]  data_i,
  input  logic [SEG_W-1:0]  ridx_i,
  output logic [ADDR_W-1:0] start_o,
  output logic [ADDR_W-1:0] len_o,
  output logic [LOOP_W-1:0] loops_o,
  output logic [ADDR_W-1:0] mark_o
);
  logic [ADDR_W-1:0] start_q [SEG_N];
  logic [ADDR_W-1:0] len_q   [SEG_N];
  logic [LOOP_W-1:0] loops_q [SEG_N];
  logic [ADDR_W-1:0] mark_q  [SEG_N];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      unique case (field_i)
        F_START: start_q[widx_i] <= data_i[ADDR_W-1:0];
        F_LEN:   len_q[widx_i]   <= data_i[ADDR_W-1:0];
        F_LOOPS: loops_q[widx_i] <= data_i[LOOP_W-1:0];
        default: mark_q[widx_i]  <= data_i[ADDR_W-1:0];
      endcase
    end
  end

  assign start_o = start_q[ridx_i];
  assign len_o   = len_q[ridx_i];
  assign loops_o = loops_q[ridx_i];
  assign mark_o  = mark_q[ridx_i];
endmodule

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import seg_seq_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int SEG_W       = 8,
  parameter int MIN_SNG_SMP = 16,
  parameter int MIN_RPT_SMP = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              trig_i,
  input  logic              trig_imm_i,
  input  logic [1:0]        mode_i,
  input  logic [SEG_W-1:0]  seg_last_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W-1:0] len_i,
  input  logic [LOOP_W-1:0] loops_i,
  input  logic [ADDR_W-1:0] mark_i,
  output logic [SEG_W-1:0]  seg_idx_o,
  output logic              iss_o,
  output logic [ADDR_W-1:0] iss_addr_o,
  output logic              iss_mark_o,
  output logic              err_o,
  output logic              active_o
);
  localparam logic [ADDR_W-1:0] MIN_SNG = ADDR_W'(MIN_SNG_SMP / SMP_PER_WORD);
  localparam logic [ADDR_W-1:0] MIN_RPT = ADDR_W'(MIN_RPT_SMP / SMP_PER_WORD);

  state_e            state_q;
  mode_e             mode;
  logic [SEG_W-1:0]  seg_q, nxt;
  logic [ADDR_W-1:0] word_q, min_len;
  logic [LOOP_W-1:0] loop_q;
  logic              pend_q, trig_q, err_q;
  logic              fire, seg_ok, last_word, last_iter, wrap, play_go, seg_end, pend_eff;

  assign mode      = mode_e'(mode_i);
  assign fire      = trig_imm_i | (trig_i & ~trig_q);
  assign min_len   = (mode == M_SINGLE) ? MIN_SNG : MIN_RPT;
  assign seg_ok    = (len_i >= min_len) && (loops_i != '0);
  assign last_word = (word_q == len_i - 1'b1);
  assign last_iter = (loop_q == loops_i - 1'b1);
  assign wrap      = (seg_q == seg_last_i);
  assign nxt       = wrap ? '0 : seg_q + 1'b1;
  assign play_go   = (state_q == S_PLAY) && adv_i;
  assign pend_eff  = pend_q | fire;
  assign seg_end   = play_go && (!seg_ok ||
                     (last_word && ((mode == M_BURST) ? pend_eff : last_iter)));

  assign iss_o      = play_go && seg_ok;
  assign iss_addr_o = start_addr_i + word_q;
  assign iss_mark_o = (word_q == mark_i);
  assign seg_idx_o  = seg_q;
  assign err_o      = err_q;
  assign active_o   = (state_q != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      seg_q   <= '0;
      word_q  <= '0;
      loop_q  <= '0;
      pend_q  <= 1'b0;
      trig_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      trig_q <= trig_i;
      err_q  <= play_go && !seg_ok;
      if (abort_i) begin
        state_q <= S_IDLE;
        word_q  <= '0;
        loop_q  <= '0;
        pend_q  <= 1'b0;
        err_q   <= 1'b0;
      end else begin
        unique case (state_q)
          S_IDLE: if (start_i) begin
            state_q <= S_WAIT;
            seg_q   <= '0;
            word_q  <= '0;
            loop_q  <= '0;
            pend_q  <= 1'b0;
          end
          S_WAIT: if (fire) state_q <= S_PLAY;
          default: begin
            if (seg_end) begin
              word_q <= '0;
              loop_q <= '0;
              pend_q <= 1'b0;
              unique case (mode)
                M_SINGLE: if (wrap) state_q <= S_IDLE; else seg_q <= nxt;
                M_STEP: begin
                  seg_q   <= nxt;
                  state_q <= S_WAIT;
                end
                default: seg_q <= nxt;
              endcase
            end else begin
              pend_q <= pend_eff;
              if (play_go) begin
                if (last_word) begin
                  word_q <= '0;
                  if (mode != M_BURST) loop_q <= loop_q + 1'b1;
                end else begin
                  word_q <= word_q + 1'b1;
                end
              end
            end
          end
        endcase
      end
    end
  end

  // R2: offsets stay inside the waveform and loop count of a legal segment
  p_word_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PLAY && seg_ok) |-> (word_q < len_i));
  p_loop_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PLAY && seg_ok && mode != M_BURST) |-> (loop_q < loops_i));
  // R10: an error pulse only follows a cycle spent playing
  p_err_from_play_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(state_q == S_PLAY));
endmodule

// File: rtl/seg_pipe.sv
module seg_pipe #(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              iss_i,
  input  logic [ADDR_W-1:0] iss_addr_i,
  input  logic              iss_mark_i,
  output logic              adv_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [WORD_W-1:0] mem_data_i,
  output logic [WORD_W-1:0] out_data_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              marker_o,
  output logic              pipe_busy_o
);
  logic              s1_v_q, s1_m_q, out_v_q, out_m_q;
  logic [WORD_W-1:0] out_d_q;

  // whole pipe, memory output register included, moves as one
  assign adv_o       = !out_v_q || out_ready_i;
  assign mem_rd_o    = adv_o;
  assign mem_addr_o  = iss_addr_i;
  assign out_data_o  = out_d_q;
  assign out_valid_o = out_v_q;
  assign marker_o    = out_m_q;
  assign pipe_busy_o = s1_v_q | out_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v_q  <= 1'b0;
      s1_m_q  <= 1'b0;
      out_v_q <= 1'b0;
      out_m_q <= 1'b0;
      out_d_q <= '0;
    end else if (abort_i) begin
      s1_v_q  <= 1'b0;
      out_v_q <= 1'b0;
      out_m_q <= 1'b0;
    end else if (adv_o) begin
      s1_v_q  <= iss_i;
      s1_m_q  <= iss_mark_i;
      out_v_q <= s1_v_q;
      out_m_q <= s1_v_q & s1_m_q;
      if (s1_v_q) out_d_q <= mem_data_i;
    end
  end

  p_hold_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_v_q && !out_ready_i && !abort_i) |=> (out_v_q && $stable(out_d_q)));
  p_marker_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    marker_o |-> out_valid_o);
endmodule

// File: rtl/seg_sequencer.sv
module seg_sequencer
  import seg_seq_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int SEG_N       = 256,
  parameter int SMP_W       = 16,
  parameter int MIN_SNG_SMP = 16,
  parameter int MIN_RPT_SMP = 32,
  localparam int SEG_W  = $clog2(SEG_N),
  localparam int WORD_W = SMP_W * SMP_PER_WORD,
  localparam int CFG_W  = (ADDR_W > LOOP_W) ? ADDR_W : LOOP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SEG_W-1:0]  cfg_idx_i,
  input  logic [1:0]        cfg_field_i,
  input  logic [CFG_W-1:0]  cfg_data_i,
  input  logic [SEG_W-1:0]  seg_last_i,
  input  logic [1:0]        mode_i,
  input  logic              trig_imm_i,
  input  logic              start_i,
  input  logic              trig_i,
  input  logic              abort_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [WORD_W-1:0] mem_data_i,
  output logic [WORD_W-1:0] out_data_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              marker_o,
  output logic              err_o,
  output logic              busy_o
);
  logic [SEG_W-1:0]  seg_idx;
  logic [ADDR_W-1:0] ent_start, ent_len, ent_mark, iss_addr;
  logic [LOOP_W-1:0] ent_loops;
  logic              adv, iss, iss_mark, active, pipe_busy;

  seg_table #(.SEG_N(SEG_N), .ADDR_W(ADDR_W), .CFG_W(CFG_W)) i_table (
    .clk_i   (clk_i),
    .we_i    (cfg_we_i),
    .widx_i  (cfg_idx_i),
    .field_i (cfg_field_i),
    .data_i  (cfg_data_i),
    .ridx_i  (seg_idx),
    .start_o (ent_start),
    .len_o   (ent_len),
    .loops_o (ent_loops),
    .mark_o  (ent_mark)
  );

  seg_ctrl #(
    .ADDR_W(ADDR_W), .SEG_W(SEG_W),
    .MIN_SNG_SMP(MIN_SNG_SMP), .MIN_RPT_SMP(MIN_RPT_SMP)
  ) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .abort_i      (abort_i),
    .trig_i       (trig_i),
    .trig_imm_i   (trig_imm_i),
    .mode_i       (mode_i),
    .seg_last_i   (seg_last_i),
    .adv_i        (adv),
    .start_addr_i (ent_start),
    .len_i        (ent_len),
    .loops_i      (ent_loops),
    .mark_i       (ent_mark),
    .seg_idx_o    (seg_idx),
    .iss_o        (iss),
    .iss_addr_o   (iss_addr),
    .iss_mark_o   (iss_mark),
    .err_o        (err_o),
    .active_o     (active)
  );

  seg_pipe #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .abort_i     (abort_i),
    .iss_i       (iss),
    .iss_addr_i  (iss_addr),
    .iss_mark_i  (iss_mark),
    .adv_o       (adv),
    .mem_rd_o    (mem_rd_o),
    .mem_addr_o  (mem_addr_o),
    .mem_data_i  (mem_data_i),
    .out_data_o  (out_data_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .marker_o    (marker_o),
    .pipe_busy_o (pipe_busy)
  );

  assign busy_o = active | pipe_busy;

  p_abort_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && !out_valid_o));
endmodule

// File: tb/test_seg_sequencer.sv
module test_seg_sequencer;
  localparam int ADDR_W = 8;
  localparam int SEG_N  = 8;
  localparam int SEG_W  = 3;
  localparam int CFG_W  = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [SEG_W-1:0] cfg_idx = '0; logic [1:0] cfg_field = '0;
  logic [CFG_W-1:0] cfg_data = '0; logic [SEG_W-1:0] seg_last = 3'd2;
  logic [1:0] mode = 2'd0; logic trig_imm = 1'b1, start = 0, trig = 0, abort = 0;
  logic mem_rd; logic [ADDR_W-1:0] mem_addr; logic [63:0] mem_q = '0;
  logic [63:0] out_data; logic out_valid, out_ready = 1'b1, marker, err, busy;

  seg_sequencer #(.ADDR_W(ADDR_W), .SEG_N(SEG_N)) i_seg_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_field_i(cfg_field), .cfg_data_i(cfg_data), .seg_last_i(seg_last),
    .mode_i(mode), .trig_imm_i(trig_imm), .start_i(start), .trig_i(trig),
    .abort_i(abort), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_data_i(mem_q),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .marker_o(marker), .err_o(err), .busy_o(busy));

  always #2 clk = ~clk;

  function automatic logic [63:0] pat(int a);
    logic [15:0] b;
    b = 16'(a * 4);
    return {b + 16'd3, b + 16'd2, b + 16'd1, b} ^ 64'hF0F0_0F0F_3C3C_C3C3;
  endfunction

  always @(posedge clk) if (mem_rd) mem_q <= pat(int'(mem_addr));

  int vec = 0, miss = 0, rcv = 0, errs = 0, bub = 0;
  bit rdy_rand = 0, chk_bub = 0, bmode = 0;
  int m_start[SEG_N], m_len[SEG_N], m_loop[SEG_N], m_mark[SEG_N];
  logic [63:0] eq_d[$]; bit eq_m[$];
  int bseg = 0, boff = 0; int biters[SEG_N];
  bit pv = 0, pr = 0, pa = 0; logic [63:0] pd = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    out_ready <= rdy_rand ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  // per-cycle comparison against the behavioural expectation
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (bmode) begin
          if (boff == 0 && out_data != pat(m_start[bseg])) bseg = (bseg + 1) % 3;
          chk(out_data == pat(m_start[bseg] + boff), "R8 burst word", out_data, pat(m_start[bseg] + boff));
          chk(marker == (boff == m_mark[bseg]), "R4 burst marker", 64'(marker), 64'(boff == m_mark[bseg]));
          boff++;
          if (boff == m_len[bseg]) begin boff = 0; biters[bseg]++; end
        end else if (eq_d.size() == 0) begin
          chk(0, "R2 word beyond expected stream", out_data, 64'd0);
        end else begin
          chk(out_data == eq_d[0], "R2 word", out_data, eq_d[0]);
          chk(marker == eq_m[0], "R4 marker", 64'(marker), 64'(eq_m[0]));
          void'(eq_d.pop_front()); void'(eq_m.pop_front());
        end
        rcv++;
      end
      if (pv && !pr && !pa)
        chk(out_valid && out_data == pd, "R3 hold under stall", out_data, pd);
      if (chk_bub && pv && pr && !out_valid && eq_d.size() > 0) bub++;
      if (err) errs++;
    end
    pv = out_valid; pr = out_ready; pd = out_data; pa = abort;
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr(input int idx, input logic [1:0] f, input int d);
    cfg_we = 1; cfg_idx = SEG_W'(idx); cfg_field = f; cfg_data = CFG_W'(d);
    tick(); cfg_we = 0;
  endtask

  // R1: field codes 0 start, 1 length, 2 loops, 3 marker
  task automatic setseg(input int i, input int s, input int l, input int lp, input int mk);
    wr(i, 2'd0, s); wr(i, 2'd1, l); wr(i, 2'd2, lp); wr(i, 2'd3, mk);
    m_start[i] = s; m_len[i] = l; m_loop[i] = lp; m_mark[i] = mk;
  endtask

  task automatic push(input int i, input int n);
    for (int it = 0; it < n; it++)
      for (int w = 0; w < m_len[i]; w++) begin
        eq_d.push_back(pat(m_start[i] + w)); eq_m.push_back(w == m_mark[i]);
      end
  endtask

  task automatic go(); start = 1; tick(); start = 0; endtask

  task automatic pulse_trig(); trig = 1; tick(); trig = 0; endtask

  task automatic wait_idle();
    for (int k = 0; k < 3000 && busy; k++) tick();
    repeat (3) tick();
  endtask

  task automatic wait_rcv(input int n);
    for (int k = 0; k < 5000 && rcv < n; k++) tick();
  endtask

  task automatic do_abort();
    abort = 1; tick(); abort = 0;
    @(negedge clk);
    chk(!out_valid, "R11 valid after abort", 64'(out_valid), 64'd0);
    chk(!busy, "R11 busy after abort", 64'(busy), 64'd0);
    eq_d.delete(); eq_m.delete();
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL watchdog expired act=%0d exp=0", rcv);
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    repeat (3) tick();
    @(negedge clk);
    chk(!out_valid && !marker && !err && !busy, "R12 reset state",
        {60'd0, out_valid, marker, err, busy}, 64'd0);
    rst_n = 1; tick();
    setseg(0, 0, 8, 2, 3);
    setseg(1, 16, 10, 1, 9);
    setseg(2, 40, 8, 3, 0);

    // single, immediate source, no backpressure
    mode = 2'd0; trig_imm = 1; chk_bub = 1; bub = 0;
    push(0, 2); push(1, 1); push(2, 3);
    go(); wait_idle();
    chk(eq_d.size() == 0, "R5 single pass complete", 64'(eq_d.size()), 64'd0);
    chk(!busy, "R5 idle after single pass", 64'(busy), 64'd0);
    chk(bub == 0, "R3 no bubble with ready high", 64'(bub), 64'd0);
    chk_bub = 0;

    // continuous with random backpressure, wraps twice
    mode = 2'd1; rdy_rand = 1; rcv = 0;
    push(0, 2); push(1, 1); push(2, 3); push(0, 2); push(1, 1); push(2, 3);
    go(); wait_rcv(70);
    chk(rcv >= 70, "R6 continuous beyond one pass", 64'(rcv), 64'd70);
    do_abort();
    rdy_rand = 0; repeat (3) tick();

    // stepped, external trigger
    mode = 2'd2; trig_imm = 0; rcv = 0;
    go(); repeat (10) tick();
    chk(rcv == 0 && !out_valid, "R9 no output before trigger", 64'(rcv), 64'd0);
    push(0, 2); pulse_trig(); repeat (60) tick();
    @(negedge clk);
    chk(eq_d.size() == 0 && rcv == 16, "R7 one segment per trigger", 64'(rcv), 64'd16);
    chk(!out_valid && out_data == pat(7), "R7 last word held", out_data, pat(7));
    push(1, 1); trig = 1; repeat (80) tick();
    @(negedge clk);
    chk(rcv == 26 && busy, "R9 held trigger counts once", 64'(rcv), 64'd26);
    chk(out_data == pat(25), "R7 last word of second segment", out_data, pat(25));
    trig = 0; tick(); push(2, 3); pulse_trig(); repeat (60) tick();
    @(negedge clk);
    chk(rcv == 50, "R2 stepped third segment", 64'(rcv), 64'd50);
    do_abort();

    // burst: loops ignored until a trigger
    mode = 2'd3; bmode = 1; bseg = 0; boff = 0; biters[0] = 0; biters[1] = 0;
    go(); pulse_trig(); repeat (60) tick();
    chk(biters[0] >= 4 && biters[1] == 0 && bseg == 0, "R8 burst repeats segment",
        64'(biters[0]), 64'd4);
    pulse_trig(); repeat (60) tick();
    chk(bseg == 1 && biters[1] >= 2, "R8 burst advances after trigger", 64'(bseg), 64'd1);
    do_abort();
    bmode = 0;

    // continuous skips a 6-word segment
    setseg(1, 16, 6, 1, 5);
    mode = 2'd1; trig_imm = 1; rcv = 0; errs = 0;
    push(0, 2); push(2, 3); push(0, 2); push(2, 3);
    go(); wait_rcv(60);
    chk(errs >= 1, "R10 short segment flagged", 64'(errs), 64'd1);
    do_abort();

    // single plays the 6-word segment, rejects zero loops
    setseg(2, 40, 8, 0, 0);
    mode = 2'd0; errs = 0;
    push(0, 2); push(1, 1);
    go(); wait_idle();
    chk(eq_d.size() == 0, "R10 6-word segment legal in single", 64'(eq_d.size()), 64'd0);
    chk(errs == 1, "R10 zero loop count rejected", 64'(errs), 64'd1);

    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule